// File: doc/BRIEF.md
# Multi-Size Fully Associative Translation Buffer

This block turns a 32-bit virtual address into a 32-bit physical address. It does this with a small set of translation entries, and any entry may hold any mapping. Each entry has its own page size: 4 KB, 64 KB, 1 MB or 16 MB. Its comparator therefore ignores a different number of low address bits, and the translated address takes its in-page offset width from the entry that matched. Software fills the entries through a write port that carries an index, a virtual base, a physical base, a size code and a valid flag. There is no hardware walker, so every mapping is preloaded.

A lookup is presented for one cycle. The result appears on registered outputs on the following clock edge:

- a hit pulse, or a miss pulse;
- the translated address;
- the index of the winning entry;
- a flag that reports overlapping matches.

A miss also raises a sticky fault interrupt, which software drops with a clear strobe. A one-cycle invalidate empties the whole buffer. A round-robin pointer proposes which entry software should overwrite next.

Top module: `vatlb`

## Requirements
- R1: After reset, the following outputs are all 0: hit, miss, multiHit, hitIdx, physAddr, irq and victimIdx. Every entry is invalid, so the first lookup misses.
- R2: When wrEn is high and invAll is low, entry wrIdx takes wrVirt, wrPhys, wrSize and wrValid at the clock edge. A lookup is affected by the write from the following cycle onward. A lookup in the same cycle still sees the old contents.
- R3: A valid entry matches when the lookup address agrees with its stored virtual base in bits [31:k]. The value of k follows the size code: 00 gives k=12 (4 KB), 01 gives k=16 (64 KB), 10 gives k=20 (1 MB) and 11 gives k=24 (16 MB).
- R4: On a hit, physAddr is the entry's physical base in bits [31:k] joined with the lookup address in bits [k-1:0]. The value is registered and appears one clock after the cycle with lookupEn high, together with a one-cycle hit pulse and hitIdx.
- R5: When lookupEn is high and no valid entry matches, the next cycle shows miss high, hit low, and physAddr and hitIdx at 0. Hit and miss are never high together.
- R6: When several valid entries match, the lowest-indexed one supplies physAddr and hitIdx, and multiHit is high with hit. With exactly one match, multiHit is low.
- R7: irq rises in the same cycle as a miss pulse and stays high until a cycle in which irqClr is high. If a new miss and irqClr occur in the same cycle, irq stays set.
- R8: invAll clears every valid bit in one cycle. A write requested in the same cycle is dropped. victimIdx returns to 0.
- R9: Each accepted write (wrEn high, invAll low) advances victimIdx by one. It wraps from ENTRIES-1 to 0. Writes to any index count.
- R10: When lookupEn is low, the next cycle shows hit, miss and multiHit low, and physAddr and hitIdx at 0.
- R11: A write with wrValid low removes that single entry from matching. Other entries are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Entry write strobe |
| wrIdx | input | $clog2(ENTRIES) | Index of the entry to write |
| wrVirt | input | 32 | Virtual base of the mapping |
| wrPhys | input | 32 | Physical base of the mapping |
| wrSize | input | 2 | Size code: 00 4 KB, 01 64 KB, 10 1 MB, 11 16 MB |
| wrValid | input | 1 | Valid flag stored with the entry |
| invAll | input | 1 | Invalidate every entry |
| lookupEn | input | 1 | Lookup request |
| lookupVa | input | 32 | Virtual address to translate |
| irqClr | input | 1 | Clears the fault interrupt |
| hit | output | 1 | Lookup found a valid entry (one clock later) |
| miss | output | 1 | Lookup found no valid entry (one clock later) |
| multiHit | output | 1 | More than one entry matched |
| hitIdx | output | $clog2(ENTRIES) | Index of the winning entry |
| physAddr | output | 32 | Translated address |
| irq | output | 1 | Sticky fault interrupt |
| victimIdx | output | $clog2(ENTRIES) | Suggested entry to replace next |

## Verification
Directed lookups place addresses at the edges of each page size: the last word inside a page and the first address just outside it. This separates the four mask widths and shows whether the offset comes from the correct entry. Overlapping mappings of different sizes separate lowest-index priority from any other ordering. Removing the lower entry then shows the fallback to the next match. Random traffic keeps the upper address bits in a narrow band, so hits, overlapping hits and misses all occur often while writes, invalidates and interrupt clears interleave with the lookups. Each outcome is compared against a reference model of the entry array kept in the bench.

// File: rtl/vatlb_pkg.sv
package vatlb_pkg;

  // Page size codes stored in each entry.
  typedef enum logic [1:0] {
    SZ_4K  = 2'b00,
    SZ_64K = 2'b01,
    SZ_1M  = 2'b10,
    SZ_16M = 2'b11
  } pageSize_e;

  // Strobes the control sends to the datapath.
  typedef struct packed {
    logic load;      // write one entry
    logic clearAll;  // drop every valid bit
    logic capture;   // register a lookup result
  } tlbStrobe_t;

  // Mask covering the in-page offset for a size code.
  function automatic logic [31:0] offsetMask(input pageSize_e sz);
    logic [31:0] m;
    case (sz)
      SZ_4K:   m = 32'h0000_0FFF;
      SZ_64K:  m = 32'h0000_FFFF;
      SZ_1M:   m = 32'h000F_FFFF;
      default: m = 32'h00FF_FFFF;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/vatlb_datapath.sv
module vatlb_datapath
  import vatlb_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int IDXW    = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  tlbStrobe_t       strobe,
  input  logic [IDXW-1:0]  wrIdx,
  input  logic [31:0]      wrVirt,
  input  logic [31:0]      wrPhys,
  input  pageSize_e        wrSize,
  input  logic             wrValid,
  input  logic [31:0]      lookupVa,
  output logic             anyMatch,
  output logic             hit,
  output logic             miss,
  output logic             multiHit,
  output logic [IDXW-1:0]  hitIdx,
  output logic [31:0]      physAddr
);

  localparam int CNTW = $clog2(ENTRIES + 1);

  logic [31:0] tagQ  [ENTRIES];
  logic [31:0] physQ [ENTRIES];
  pageSize_e   sizeQ [ENTRIES];
  logic [31:0] maskW [ENTRIES];
  logic [ENTRIES-1:0] validQ;
  logic [ENTRIES-1:0] matchW;

  // Entry storage and per-entry masked compare.
  for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        validQ[e] <= 1'b0;
        tagQ[e]   <= '0;
        physQ[e]  <= '0;
        sizeQ[e]  <= SZ_4K;
      end else if (strobe.clearAll) begin
        validQ[e] <= 1'b0;
      end else if (strobe.load && wrIdx == IDXW'(e)) begin
        validQ[e] <= wrValid;
        tagQ[e]   <= wrVirt;
        physQ[e]  <= wrPhys;
        sizeQ[e]  <= wrSize;
      end
    end

    assign maskW[e]  = offsetMask(sizeQ[e]);
    assign matchW[e] = validQ[e] && (((lookupVa ^ tagQ[e]) & ~maskW[e]) == 32'h0);
  end

  // Lowest index wins; count matches for overlap detection.
  logic [IDXW-1:0] selIdx;
  logic            found;
  logic [CNTW-1:0] matchCnt;
  logic [31:0]     translated;

  always_comb begin
    selIdx   = '0;
    found    = 1'b0;
    matchCnt = '0;
    for (int e = 0; e < ENTRIES; e++) begin
      if (matchW[e]) begin
        if (!found) begin
          selIdx = IDXW'(e);
          found  = 1'b1;
        end
        matchCnt = matchCnt + CNTW'(1);
      end
    end
  end

  assign translated = (physQ[selIdx] & ~maskW[selIdx]) | (lookupVa & maskW[selIdx]);
  assign anyMatch   = found;

  // Registered lookup result.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hit      <= 1'b0;
      miss     <= 1'b0;
      multiHit <= 1'b0;
      hitIdx   <= '0;
      physAddr <= '0;
    end else begin
      hit      <= strobe.capture && found;
      miss     <= strobe.capture && !found;
      multiHit <= strobe.capture && (matchCnt > CNTW'(1));
      hitIdx   <= (strobe.capture && found) ? selIdx : '0;
      physAddr <= (strobe.capture && found) ? translated : 32'h0;
    end
  end

endmodule

// File: rtl/vatlb_ctrl.sv
module vatlb_ctrl
  import vatlb_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int IDXW    = $clog2(ENTRIES)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            wrEn,
  input  logic            invAll,
  input  logic            lookupEn,
  input  logic            irqClr,
  input  logic            anyMatch,
  output tlbStrobe_t      strobe,
  output logic [IDXW-1:0] victimIdx,
  output logic            irq
);

  localparam logic [IDXW-1:0] LAST_IDX = IDXW'(ENTRIES - 1);

  logic acceptWr;
  logic missNow;

  assign acceptWr = wrEn && !invAll;
  assign missNow  = lookupEn && !anyMatch;

  always_comb begin
    strobe.load     = acceptWr;
    strobe.clearAll = invAll;
    strobe.capture  = lookupEn;
  end

  // Round-robin replacement suggestion.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      victimIdx <= '0;
    end else if (invAll) begin
      victimIdx <= '0;
    end else if (acceptWr) begin
      victimIdx <= (victimIdx == LAST_IDX) ? '0 : victimIdx + IDXW'(1);
    end
  end

  // Sticky fault line; a fresh miss outranks a clear.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irq <= 1'b0;
    end else begin
      irq <= (irq && !irqClr) || missNow;
    end
  end

endmodule

// File: rtl/vatlb.sv
module vatlb
  import vatlb_pkg::*;
#(
  parameter int ENTRIES = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       wrEn,
  input  logic [$clog2(ENTRIES)-1:0] wrIdx,
  input  logic [31:0]                wrVirt,
  input  logic [31:0]                wrPhys,
  input  logic [1:0]                 wrSize,
  input  logic                       wrValid,
  input  logic                       invAll,
  input  logic                       lookupEn,
  input  logic [31:0]                lookupVa,
  input  logic                       irqClr,
  output logic                       hit,
  output logic                       miss,
  output logic                       multiHit,
  output logic [$clog2(ENTRIES)-1:0] hitIdx,
  output logic [31:0]                physAddr,
  output logic                       irq,
  output logic [$clog2(ENTRIES)-1:0] victimIdx
);

  localparam int IDXW = $clog2(ENTRIES);

  tlbStrobe_t strobe;
  logic       anyMatch;

  vatlb_ctrl #(.ENTRIES(ENTRIES), .IDXW(IDXW)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (wrEn),
    .invAll    (invAll),
    .lookupEn  (lookupEn),
    .irqClr    (irqClr),
    .anyMatch  (anyMatch),
    .strobe    (strobe),
    .victimIdx (victimIdx),
    .irq       (irq)
  );

  vatlb_datapath #(.ENTRIES(ENTRIES), .IDXW(IDXW)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .wrIdx    (wrIdx),
    .wrVirt   (wrVirt),
    .wrPhys   (wrPhys),
    .wrSize   (pageSize_e'(wrSize)),
    .wrValid  (wrValid),
    .lookupVa (lookupVa),
    .anyMatch (anyMatch),
    .hit      (hit),
    .miss     (miss),
    .multiHit (multiHit),
    .hitIdx   (hitIdx),
    .physAddr (physAddr)
  );

endmodule

// File: rtl/vatlb_checker.sv
module vatlb_checker #(
  parameter int ENTRIES = 8
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       wrEn,
  input logic                       invAll,
  input logic                       lookupEn,
  input logic [31:0]                lookupVa,
  input logic                       irqClr,
  input logic                       hit,
  input logic                       miss,
  input logic                       multiHit,
  input logic [31:0]                physAddr,
  input logic                       irq,
  input logic [$clog2(ENTRIES)-1:0] victimIdx
);

  localparam int IDXW = $clog2(ENTRIES);
  localparam logic [IDXW-1:0] LAST_IDX = IDXW'(ENTRIES - 1);

  logic [31:0] vaPrev;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) vaPrev <= '0;
    else       vaPrev <= lookupVa;
  end

  // R5: outcomes are exclusive
  p_hit_miss_excl_r5: assert property (@(posedge clk) disable iff (!rstN)
    !(hit && miss));

  // R7: every miss leaves the interrupt raised
  p_miss_sets_irq_r7: assert property (@(posedge clk) disable iff (!rstN)
    miss |-> irq);

  // R7: a clear without a new miss drops the interrupt
  p_irq_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    ($past(irqClr) && !miss) |-> !irq);

  // R10: no request, no result
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    !$past(lookupEn) |-> (!hit && !miss && !multiHit && physAddr == 32'h0));

  // R6: overlap only reported on a hit
  p_multi_implies_hit_r6: assert property (@(posedge clk) disable iff (!rstN)
    multiHit |-> hit);

  // R4: the smallest page offset always passes through
  p_offset_kept_r4: assert property (@(posedge clk) disable iff (!rstN)
    hit |-> (physAddr[11:0] == vaPrev[11:0]));

  // R9: accepted writes step the pointer with wrap
  p_victim_step_r9: assert property (@(posedge clk) disable iff (!rstN)
    ($past(wrEn) && !$past(invAll)) |->
      (victimIdx == (($past(victimIdx) == LAST_IDX) ? '0 : $past(victimIdx) + IDXW'(1))));

  // R8: invalidate resets pointer and empties the buffer
  p_inv_ptr_r8: assert property (@(posedge clk) disable iff (!rstN)
    $past(invAll) |-> (victimIdx == '0));

  p_inv_clears_r8: assert property (@(posedge clk) disable iff (!rstN)
    ($past(invAll, 2) && $past(lookupEn)) |-> miss);

endmodule

bind vatlb vatlb_checker #(.ENTRIES(ENTRIES)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .wrEn      (wrEn),
  .invAll    (invAll),
  .lookupEn  (lookupEn),
  .lookupVa  (lookupVa),
  .irqClr    (irqClr),
  .hit       (hit),
  .miss      (miss),
  .multiHit  (multiHit),
  .physAddr  (physAddr),
  .irq       (irq),
  .victimIdx (victimIdx)
);

// File: tb/vatlb_bench.sv
module vatlb_bench;

  localparam int N    = 8;
  localparam int IDXW = $clog2(N);

  logic            clk = 1'b0;
  logic            rstN;
  logic            wrEn, wrValid, invAll, lookupEn, irqClr;
  logic [IDXW-1:0] wrIdx;
  logic [31:0]     wrVirt, wrPhys, lookupVa;
  logic [1:0]      wrSize;
  logic            hit, miss, multiHit, irq;
  logic [IDXW-1:0] hitIdx, victimIdx;
  logic [31:0]     physAddr;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #10 clk = ~clk;  // 50 MHz

  vatlb #(.ENTRIES(N)) u_vatlb (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrIdx(wrIdx), .wrVirt(wrVirt),
    .wrPhys(wrPhys), .wrSize(wrSize), .wrValid(wrValid), .invAll(invAll),
    .lookupEn(lookupEn), .lookupVa(lookupVa), .irqClr(irqClr),
    .hit(hit), .miss(miss), .multiHit(multiHit), .hitIdx(hitIdx),
    .physAddr(physAddr), .irq(irq), .victimIdx(victimIdx)
  );

  // Reference model of the entry array.
  logic [31:0] mTag  [N];
  logic [31:0] mPhys [N];
  logic [1:0]  mSize [N];
  bit          mValid[N];
  int          mVictim;
  bit          mIrq;

  function automatic logic [31:0] maskOf(input logic [1:0] s);
    case (s)
      2'b00:   return 32'h0000_0FFF;
      2'b01:   return 32'h0000_FFFF;
      2'b10:   return 32'h000F_FFFF;
      default: return 32'h00FF_FFFF;
    endcase
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // One clock: drive at negedge, predict, check just after the posedge.
  task automatic cyc(input bit we, input int idx, input logic [31:0] va,
                     input logic [31:0] pa, input logic [1:0] sz, input bit vld,
                     input bit inv, input bit le, input logic [31:0] lva,
                     input bit clr, input string req);
    bit found = 0;
    int cnt = 0;
    int eIdx = 0;
    logic [31:0] ePa = 0;
    bit eHit, eMiss, eMulti;
    @(negedge clk);
    wrEn = we; wrIdx = IDXW'(idx); wrVirt = va; wrPhys = pa; wrSize = sz;
    wrValid = vld; invAll = inv; lookupEn = le; lookupVa = lva; irqClr = clr;
    for (int e = 0; e < N; e++) begin
      if (mValid[e] && (((lva ^ mTag[e]) & ~maskOf(mSize[e])) == 0)) begin
        if (!found) begin
          found = 1;
          eIdx  = e;
          ePa   = (mPhys[e] & ~maskOf(mSize[e])) | (lva & maskOf(mSize[e]));
        end
        cnt++;
      end
    end
    eHit   = le && found;
    eMiss  = le && !found;
    eMulti = le && (cnt > 1);
    mIrq   = (mIrq && !clr) || eMiss;
    if (inv) begin
      for (int e = 0; e < N; e++) mValid[e] = 0;
      mVictim = 0;
    end else if (we) begin
      mTag[idx] = va; mPhys[idx] = pa; mSize[idx] = sz; mValid[idx] = vld;
      mVictim = (mVictim + 1) % N;
    end
    @(posedge clk);
    #1;
    chk(req, "hit",      32'(hit),       32'(eHit));
    chk(req, "miss",     32'(miss),      32'(eMiss));
    chk(req, "multiHit", 32'(multiHit),  32'(eMulti));
    chk(req, "hitIdx",   32'(hitIdx),    eHit ? 32'(eIdx) : 32'h0);
    chk(req, "physAddr", physAddr,       eHit ? ePa : 32'h0);
    chk(req, "irq",      32'(irq),       32'(mIrq));
    chk(req, "victim",   32'(victimIdx), 32'(mVictim));
  endtask

  task automatic look(input logic [31:0] lva, input string req);
    cyc(0, 0, 0, 0, 0, 0, 0, 1, lva, 0, req);
  endtask

  task automatic load(input int idx, input logic [31:0] va, input logic [31:0] pa,
                      input logic [1:0] sz, input bit vld, input string req);
    cyc(1, idx, va, pa, sz, vld, 0, 0, 0, 0, req);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    rstN = 0; wrEn = 0; wrIdx = 0; wrVirt = 0; wrPhys = 0; wrSize = 0;
    wrValid = 0; invAll = 0; lookupEn = 0; lookupVa = 0; irqClr = 0;
    for (int e = 0; e < N; e++) begin
      mTag[e] = 0; mPhys[e] = 0; mSize[e] = 0; mValid[e] = 0;
    end
    mVictim = 0; mIrq = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;
    #1;
    // R1: reset state at the ports
    chk("R1", "hit",      32'(hit),       0);
    chk("R1", "miss",     32'(miss),      0);
    chk("R1", "physAddr", physAddr,       0);
    chk("R1", "irq",      32'(irq),       0);
    chk("R1", "victim",   32'(victimIdx), 0);

    look(32'h1234_5678, "R1");                           // empty buffer misses, irq rises (R7)
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, "R7");             // clear drops irq
    look(32'h0000_0000, "R10");
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, "R7");
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 32'h1234_5678, 0, "R10"); // idle lookupEn low

    // R2: same-cycle lookup sees old contents, next cycle sees new entry
    cyc(1, 0, 32'h1234_5000, 32'hABCD_E000, 2'b00, 1, 0, 1, 32'h1234_5678, 1, "R2");
    look(32'h1234_5678, "R4");                           // 4 KB translate
    look(32'h1234_5FFF, "R3");                           // last byte inside page
    look(32'h1234_6000, "R3");                           // just outside
    load(1, 32'h4001_0000, 32'h8000_0000, 2'b01, 1, "R9");
    look(32'h4001_FFFC, "R4");
    look(32'h4002_0000, "R3");
    load(2, 32'h0050_0000, 32'hC030_0000, 2'b10, 1, "R9");
    look(32'h005A_BCDE, "R4");
    look(32'h0060_0000, "R3");
    load(3, 32'h7F00_0000, 32'h0100_0000, 2'b11, 1, "R9");
    look(32'h7F12_3456, "R4");
    look(32'h7FFF_FFFF, "R3");
    look(32'h8000_0000, "R5");
    // R6: overlapping 16 MB entry at higher index
    load(5, 32'h1200_0000, 32'h3300_0000, 2'b11, 1, "R2");
    look(32'h1234_5678, "R6");
    look(32'h12FF_0000, "R6");
    // R11: invalidate entry 0 alone
    load(0, 32'h1234_5000, 32'hABCD_E000, 2'b00, 0, "R11");
    look(32'h1234_5678, "R11");
    look(32'h7F00_0010, "R11");
    // R7: miss and clear together keeps irq
    cyc(0, 0, 0, 0, 0, 0, 0, 1, 32'hDEAD_0000, 1, "R7");
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R7");
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, "R7");
    // R8: invalidate with a simultaneous write
    cyc(1, 6, 32'h7F00_0000, 32'h0200_0000, 2'b11, 1, 1, 0, 0, 0, "R8");
    look(32'h7F12_3456, "R8");
    look(32'h4001_0000, "R8");
    // R9: wrap the pointer
    for (int i = 0; i < N + 2; i++)
      load(i % N, 32'h0100_0000 * i, 32'h0010_0000 * i, 2'(i), 1, "R9");
    look(32'h0300_0004, "R3");

    // Random phase
    void'($urandom(32'd13579));
    for (int i = 0; i < 600; i++) begin
      int r = $urandom % 16;
      bit we = (r < 5);
      bit inv = (r == 15) && ($urandom % 4 == 0);
      bit le = ($urandom % 4) != 0;
      bit clr = ($urandom % 5) == 0;
      int idx = $urandom % N;
      logic [31:0] va = {6'b000100, 26'($urandom)};
      logic [31:0] pa = $urandom;
      logic [1:0] sz = 2'($urandom);
      bit vld = ($urandom % 8) != 0;
      logic [31:0] lva;
      int pick = $urandom % N;
      if ($urandom % 4 == 0) lva = {6'b000100, 26'($urandom)};
      else lva = mTag[pick] ^ ($urandom & maskOf(mSize[pick]));
      cyc(we, idx, va, pa, sz, vld, inv, le, lva, clr, "R3");
    end
    finishRun();
  end

endmodule